// File: doc/BRIEF.md
# Level Trigger with Delayed Capture

The block watches a stream of signed 16-bit samples and raises a trigger when the signal rises through a programmable threshold. The threshold is set by a signed 12-bit level, scaled to the sample range by a left shift of four bits. A hysteresis band of 20 counts below the threshold keeps noise from turning one crossing into several triggers.

The same block steers writes into a circular capture buffer. The buffer holds 384 bytes. The number of sample slots it offers depends on the selected data format. A signed delay sets where the record begins, counted in samples from the trigger sample. A negative delay places the record before the trigger. A positive delay of up to 2^31-1 places it after. The delay is checked against a per-format pre-trigger limit when the block is armed. Once the last sample of the record has been written, the block reports the slot where the record starts and raises a done flag.

Top module: `lvtrig_capture`

## Requirements
- R1: After reset, `done`, `param_err` and `buf_we` are 0.
- R2: The threshold is `trig_level` (signed) times 16. A valid sample that is greater than or equal to the threshold fires a trigger, provided the detector is re-armed.
- R3: Firing disarms the detector. It re-arms only on a valid sample at or below threshold minus 20. The detector also starts disarmed after reset.
- R4: While `gen_en` is 0, crossings are not taken as triggers, but they still disarm the detector.
- R5: `fmt_sel` selects the buffer slot count: 0 gives 256, 1 gives 128, 2 gives 128 and 3 gives 64. The minimum delay is 48 minus the slot count. An arm with a delay below that minimum sets `param_err`, keeps the block idle and writes nothing. An arm with an accepted delay clears `param_err`.
- R6: After an accepted arm, the n-th valid sample (counting from 0) is written with `buf_we` high at address n modulo the slot count. `buf_we` follows `smp_valid` in the same cycle. Nothing is written in the cycle of an arm.
- R7: For a negative delay d, a trigger is ignored until the current sample index is at least -d.
- R8: With the trigger on sample index T, `rec_start` equals (T + delay) modulo the slot count once `done` is high.
- R9: `done` rises after the write of sample index T + delay + 31, since a record is 32 samples. If that index is not greater than T, `done` rises on the trigger sample itself. After `done`, writes stop and `done` holds until the next arm.
- R10: An arm in any state restarts acquisition from index 0 and clears `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 16 | Signed sample |
| trig_level | input | 12 | Signed threshold level |
| trig_delay | input | 32 | Signed record delay in samples, latched at arm |
| gen_en | input | 1 | Allows triggers to be taken |
| fmt_sel | input | 2 | Data format code, latched at arm |
| arm | input | 1 | Single-cycle pulse that starts an acquisition |
| buf_we | output | 1 | Buffer write enable |
| buf_waddr | output | 8 | Buffer write address |
| rec_start | output | 8 | Slot of the first record sample |
| done | output | 1 | Record complete |
| param_err | output | 1 | Last arm carried an out-of-range delay |

## Verification
`buf_we` and `buf_waddr` are combinational from the registered sample index and the live strobe. The bench therefore reads them one time unit after driving a sample, in the same cycle. `done`, `param_err` and `rec_start` are registered on the edge that takes the sample or the arm. They are read at the following falling edge, one cycle later. A bench reference model is stepped between those two sampling points, so each expectation lines up with the edge that produces it.

// File: rtl/lvtrig_pkg.sv
// Shared types and format arithmetic for the level-trigger capture block.
// Assumes the buffer byte count divided by each format's bytes per sample is a power of two.
package lvtrig_pkg;
    typedef enum logic [1:0] {FMT_R12 = 2'd0, FMT_C12 = 2'd1, FMT_R24 = 2'd2, FMT_C24 = 2'd3} fmt_e;
    typedef enum logic [1:0] {ST_IDLE, ST_ACQ, ST_POST, ST_DONE} cap_st_e;

    localparam int GUARD_SAMPLES = 48;

    // Bytes per sample, doubled so that 1.5 bytes stays an integer.
    function automatic int half_bytes(fmt_e f);
        case (f)
            FMT_R12: return 3;
            FMT_C24: return 12;
            default: return 6;
        endcase
    endfunction

    function automatic int slot_count(int buf_bytes, fmt_e f);
        return (buf_bytes * 2) / half_bytes(f);
    endfunction

    function automatic int min_delay(int buf_bytes, fmt_e f);
        return GUARD_SAMPLES - slot_count(buf_bytes, f);
    endfunction
endpackage

// File: rtl/lvtrig_level_det.sv
// Rising-threshold detector with a hysteresis re-arm band.
// Assumes: threshold = level << (SAMPLE_W-LEVEL_W); starts disarmed after reset.
module lvtrig_level_det #(
    parameter int SAMPLE_W = 16,
    parameter int LEVEL_W  = 12,
    parameter int HYST     = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic [LEVEL_W-1:0]  trig_level,
    output logic                fire
);
    localparam int SHIFT = SAMPLE_W - LEVEL_W;
    localparam int EXT_W = SAMPLE_W + 1;

    logic signed [EXT_W-1:0] thr_ext;
    logic signed [EXT_W-1:0] low_ext;
    logic signed [EXT_W-1:0] smp_ext;
    logic                    ready_q;

    // Scale the level to sample counts and form the re-arm bound.
    always_comb begin
        thr_ext = EXT_W'($signed({trig_level, {SHIFT{1'b0}}}));
        low_ext = thr_ext - EXT_W'(HYST);
        smp_ext = EXT_W'($signed(smp_data));
        fire    = smp_valid && ready_q && (smp_ext >= thr_ext);
    end

    // Disarm on firing, re-arm once the signal drops through the band.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ready_q <= 1'b0;
        else if (fire)
            ready_q <= 1'b0;
        else if (smp_valid && (smp_ext <= low_ext))
            ready_q <= 1'b1;
    end
endmodule

// File: rtl/lvtrig_delay_chk.sv
// Compares a requested signed delay against the pre-trigger floor of each format.
// Assumes: combinational; the caller samples the result on its arm pulse.
module lvtrig_delay_chk
    import lvtrig_pkg::*;
#(
    parameter int BUF_BYTES = 384,
    parameter int DELAY_W   = 32
) (
    input  logic [1:0]         fmt_sel,
    input  logic [DELAY_W-1:0] trig_delay,
    output logic               delay_bad
);
    localparam int NFMT = 4;

    logic signed [DELAY_W-1:0] floor_tab [NFMT];

    // One floor per format code.
    for (genvar g = 0; g < NFMT; g++) begin : g_floor
        assign floor_tab[g] = DELAY_W'(min_delay(BUF_BYTES, fmt_e'(g)));
    end

    // Out of range when below the selected floor.
    always_comb delay_bad = $signed(trig_delay) < floor_tab[fmt_sel];
endmodule

// File: rtl/lvtrig_capture_ctrl.sv
// Sequencer for the circular capture: arm, pre-fill, trigger, post-count, done.
// Assumes: arm is a single-cycle pulse; fmt and delay are latched at arm time.
module lvtrig_capture_ctrl
    import lvtrig_pkg::*;
#(
    parameter int BUF_BYTES = 384,
    parameter int DELAY_W   = 32,
    parameter int REC_LEN   = 32,
    parameter int ADDR_W    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               smp_valid,
    input  logic               fire,
    input  logic               gen_en,
    input  logic               arm,
    input  logic               delay_bad,
    input  logic [1:0]         fmt_sel,
    input  logic [DELAY_W-1:0] trig_delay,
    output logic               buf_we,
    output logic [ADDR_W-1:0]  buf_waddr,
    output logic [ADDR_W-1:0]  rec_start,
    output logic               done,
    output logic               param_err
);
    localparam int REM_W = DELAY_W + 1;

    cap_st_e                  st_q;
    fmt_e                     fmt_q;
    logic [DELAY_W-1:0]       dly_q;
    logic [DELAY_W-1:0]       idx_q;
    logic                     filled_q;
    logic signed [REM_W-1:0]  rem_q;
    logic [ADDR_W-1:0]        mask;
    logic [DELAY_W-1:0]       need;
    logic                     pre_ok;
    logic                     take;
    logic signed [REM_W-1:0]  rem_init;

    // Derive the address mask, pre-fill depth and trigger acceptance.
    always_comb begin
        mask      = ADDR_W'(slot_count(BUF_BYTES, fmt_q) - 1);
        need      = dly_q[DELAY_W-1] ? (~dly_q + 1'b1) : '0;
        pre_ok    = filled_q || (idx_q >= need);
        take      = fire && gen_en && pre_ok;
        rem_init  = $signed({dly_q[DELAY_W-1], dly_q}) + REM_W'(REC_LEN - 1);
        buf_we    = smp_valid && !arm && ((st_q == ST_ACQ) || (st_q == ST_POST));
        buf_waddr = ADDR_W'(idx_q) & mask;
    end

    // Step the capture sequence on arm and on each valid sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            fmt_q     <= FMT_R12;
            dly_q     <= '0;
            idx_q     <= '0;
            filled_q  <= 1'b0;
            rem_q     <= '0;
            rec_start <= '0;
            done      <= 1'b0;
            param_err <= 1'b0;
        end else if (arm) begin
            done     <= 1'b0;
            idx_q    <= '0;
            filled_q <= 1'b0;
            if (delay_bad) begin
                st_q      <= ST_IDLE;
                param_err <= 1'b1;
            end else begin
                st_q      <= ST_ACQ;
                param_err <= 1'b0;
                fmt_q     <= fmt_e'(fmt_sel);
                dly_q     <= trig_delay;
            end
        end else if (smp_valid) begin
            case (st_q)
                ST_ACQ: begin
                    idx_q <= idx_q + 1'b1;
                    if (pre_ok) filled_q <= 1'b1;
                    if (take) begin
                        rec_start <= ADDR_W'(idx_q + dly_q) & mask;
                        rem_q     <= rem_init;
                        if (rem_init <= 0) begin
                            st_q <= ST_DONE;
                            done <= 1'b1;
                        end else begin
                            st_q <= ST_POST;
                        end
                    end
                end
                ST_POST: begin
                    idx_q <= idx_q + 1'b1;
                    if (rem_q == 1) begin
                        st_q <= ST_DONE;
                        done <= 1'b1;
                    end else begin
                        rem_q <= rem_q - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/lvtrig_capture.sv
// Top: level trigger with hysteresis driving a delayed circular capture.
// Assumes: samples arrive one per valid strobe; the buffer sits outside this block.
module lvtrig_capture #(
    parameter int SAMPLE_W  = 16,
    parameter int LEVEL_W   = 12,
    parameter int DELAY_W   = 32,
    parameter int BUF_BYTES = 384,
    parameter int REC_LEN   = 32,
    parameter int HYST      = 20,
    parameter int ADDR_W    = $clog2((BUF_BYTES * 2) / 3)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic [LEVEL_W-1:0]  trig_level,
    input  logic [DELAY_W-1:0]  trig_delay,
    input  logic                gen_en,
    input  logic [1:0]          fmt_sel,
    input  logic                arm,
    output logic                buf_we,
    output logic [ADDR_W-1:0]   buf_waddr,
    output logic [ADDR_W-1:0]   rec_start,
    output logic                done,
    output logic                param_err
);
    logic fire;
    logic delay_bad;

    lvtrig_level_det #(.SAMPLE_W(SAMPLE_W), .LEVEL_W(LEVEL_W), .HYST(HYST)) u_det (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .trig_level(trig_level), .fire(fire)
    );

    lvtrig_delay_chk #(.BUF_BYTES(BUF_BYTES), .DELAY_W(DELAY_W)) u_dchk (
        .fmt_sel(fmt_sel), .trig_delay(trig_delay), .delay_bad(delay_bad)
    );

    lvtrig_capture_ctrl #(.BUF_BYTES(BUF_BYTES), .DELAY_W(DELAY_W), .REC_LEN(REC_LEN),
                          .ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .fire(fire), .gen_en(gen_en),
        .arm(arm), .delay_bad(delay_bad), .fmt_sel(fmt_sel), .trig_delay(trig_delay),
        .buf_we(buf_we), .buf_waddr(buf_waddr), .rec_start(rec_start),
        .done(done), .param_err(param_err)
    );
endmodule

// File: rtl/lvtrig_capture_chk.sv
// Property checker for lvtrig_capture, attached with bind.
// Assumes: observes the top-level ports only.
module lvtrig_capture_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              arm,
    input logic              buf_we,
    input logic [ADDR_W-1:0] buf_waddr,
    input logic              done,
    input logic              param_err
);
    p_err_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        param_err |-> !buf_we);

    p_err_from_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(param_err) |-> $past(arm));

    p_done_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !buf_we);

    p_done_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !arm) |=> done);

    p_arm_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> !done);

    p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_we && $past(buf_we)) |->
            ((buf_waddr == ADDR_W'($past(buf_waddr) + 1'b1)) || (buf_waddr == '0)));
endmodule

bind lvtrig_capture lvtrig_capture_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .arm(arm), .buf_we(buf_we), .buf_waddr(buf_waddr),
    .done(done), .param_err(param_err)
);

// File: tb/lvtrig_capture_tb_top.sv
// Bench: directed corner cases plus seeded random runs against a reference model.
module lvtrig_capture_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic [11:0] trig_level = '0;
    logic [31:0] trig_delay = '0;
    logic        gen_en = 1'b1;
    logic [1:0]  fmt_sel = '0;
    logic        arm = 1'b0;
    logic        buf_we;
    logic [7:0]  buf_waddr;
    logic [7:0]  rec_start;
    logic        done;
    logic        param_err;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // Reference model state.
    int m_rdy = 0, m_st = 0, m_idx = 0, m_filled = 0, m_err = 0, m_done = 0;
    int m_start = 0, m_fmt = 0, m_dly = 0;
    longint m_rem = 0;

    always #4 clk = ~clk;

    lvtrig_capture dut_i (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .trig_level(trig_level), .trig_delay(trig_delay), .gen_en(gen_en),
        .fmt_sel(fmt_sel), .arm(arm), .buf_we(buf_we), .buf_waddr(buf_waddr),
        .rec_start(rec_start), .done(done), .param_err(param_err)
    );

    function automatic int slots(int f);
        return 768 / ((f == 0) ? 3 : (f == 3) ? 12 : 6);
    endfunction

    function automatic int floor_of(int f);
        return 48 - slots(f);
    endfunction

    task automatic check(string tag, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    // One cycle: drive, check combinational writes, step model, check registers.
    task automatic tick(bit v, int s, bit a);
        int thr;
        bit fire;
        bit pre;
        bit exp_we;
        smp_valid = v;
        smp_data  = s[15:0];
        arm       = a;
        #1;
        exp_we = v && !a && (m_st == 1 || m_st == 2);
        check("R6 write enable", int'(buf_we), int'(exp_we));
        if (exp_we) check("R6 write address", int'(buf_waddr), m_idx & (slots(m_fmt) - 1));
        thr  = int'($signed(trig_level)) * 16;
        fire = v && (m_rdy != 0) && (s >= thr);
        if (a) begin
            m_done = 0; m_idx = 0; m_filled = 0;
            if (int'($signed(trig_delay)) < floor_of(int'(fmt_sel))) begin
                m_st = 0; m_err = 1;
            end else begin
                m_st = 1; m_err = 0; m_fmt = int'(fmt_sel); m_dly = int'($signed(trig_delay));
            end
        end else if (v && m_st == 1) begin
            pre = (m_filled != 0) || (m_dly >= 0) || (m_idx >= -m_dly);
            if (fire && gen_en && pre) begin
                m_start = (m_idx + m_dly) & (slots(m_fmt) - 1);
                m_rem = longint'(m_dly) + 31;
                if (m_rem <= 0) begin m_st = 3; m_done = 1; end
                else m_st = 2;
            end
            if (pre) m_filled = 1;
            m_idx++;
        end else if (v && m_st == 2) begin
            m_idx++;
            if (m_rem == 1) begin m_st = 3; m_done = 1; end
            else m_rem--;
        end
        if (v) begin
            if (fire) m_rdy = 0;
            else if (s <= thr - 20) m_rdy = 1;
        end
        @(posedge clk);
        @(negedge clk);
        check("R9 done", int'(done), m_done);
        check("R5 param_err", int'(param_err), m_err);
        if (m_done != 0) check("R8 rec_start", int'(rec_start), m_start);
    endtask

    task automatic setup(int f, int d, int lvl, bit g);
        fmt_sel = f[1:0]; trig_delay = d; trig_level = lvl[11:0]; gen_en = g;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1 done after reset", int'(done), 0);
        check("R1 param_err after reset", int'(param_err), 0);
        check("R1 write enable after reset", int'(buf_we), 0);
        @(negedge clk);

        // R2, R8, R9: delay 0, threshold 1600, trigger at index 5
        setup(0, 0, 100, 1'b1);
        tick(1'b0, 0, 1'b1);
        for (int i = 0; i < 5; i++) tick(1'b1, -1000, 1'b0);
        tick(1'b1, 1600, 1'b0);
        for (int i = 0; i < 30; i++) tick(1'b1, 500, 1'b0);
        check("R9 not done before last record sample", int'(done), 0);
        tick(1'b1, 500, 1'b0);
        check("R9 done on last record sample", int'(done), 1);
        check("R2 R8 start at trigger index 5", int'(rec_start), 5);
        tick(1'b1, 500, 1'b0);
        check("R9 no write after done", int'(buf_we), 0);

        // R3, R4: gen_en off consumes a crossing; shallow dip does not re-arm
        setup(0, 5, 0, 1'b0);
        tick(1'b0, 0, 1'b1);
        tick(1'b1, -100, 1'b0);
        tick(1'b1, 50, 1'b0);
        gen_en = 1'b1;
        tick(1'b1, 50, 1'b0);
        tick(1'b1, -19, 1'b0);
        tick(1'b1, 50, 1'b0);
        check("R3 R4 no trigger yet", int'(done), 0);
        tick(1'b1, -20, 1'b0);
        tick(1'b1, 50, 1'b0);
        for (int i = 0; i < 36; i++) tick(1'b1, 0, 1'b0);
        check("R3 done after re-armed trigger", int'(done), 1);
        check("R3 start at index 6 plus 5", int'(rec_start), 11);

        // R7: pre-trigger fill gates the trigger; delay -40, format 1
        setup(1, -40, 0, 1'b1);
        tick(1'b0, 0, 1'b1);
        tick(1'b1, -100, 1'b0);
        tick(1'b1, 50, 1'b0);
        for (int i = 2; i < 45; i++) tick(1'b1, -100, 1'b0);
        check("R7 early crossing ignored", int'(done), 0);
        tick(1'b1, 50, 1'b0);
        check("R7 R9 done on trigger sample", int'(done), 1);
        check("R7 start index 45 minus 40", int'(rec_start), 5);

        // R5: format 3 floor is -16
        setup(3, -17, 0, 1'b1);
        tick(1'b0, 0, 1'b1);
        check("R5 error on -17", int'(param_err), 1);
        for (int i = 0; i < 4; i++) tick(1'b1, i * 100 - 200, 1'b0);
        check("R5 no write while in error", int'(buf_we), 0);
        setup(3, -16, 0, 1'b1);
        tick(1'b0, 0, 1'b1);
        check("R5 error cleared on -16", int'(param_err), 0);

        // R10: re-arm mid-capture restarts at index 0
        setup(2, 10, 0, 1'b1);
        tick(1'b0, 0, 1'b1);
        for (int i = 0; i < 20; i++) tick(1'b1, 0, 1'b0);
        tick(1'b0, 0, 1'b1);
        smp_valid = 1'b1; smp_data = '0; arm = 1'b0;
        #1;
        check("R10 address restarts at 0", int'(buf_waddr), 0);
        check("R10 done cleared", int'(done), 0);
        @(negedge clk);
        smp_valid = 1'b0;

        // Random runs against the model
        for (int n = 0; n < 40; n++) begin
            int f, d, lvl, thr;
            f   = int'($urandom % 4);
            lvl = int'($urandom % 64) - 32;
            if ($urandom % 8 == 0) d = floor_of(f) - 1 - int'($urandom % 5);
            else d = floor_of(f) + int'($urandom % (53 - floor_of(f)));
            setup(f, d, lvl, ($urandom % 8) != 0);
            thr = lvl * 16;
            tick(1'b0, 0, 1'b1);
            for (int c = 0; c < 700; c++) begin
                if (m_done != 0 || m_err != 0) break;
                tick(($urandom % 4) != 0, thr + int'($urandom % 200) - 100, 1'b0);
            end
        end
        report();
    end
endmodule